// File: doc/BRIEF.md
# Prioritising Interrupt Controller with Acknowledge

This block gathers up to 96 level-sensitive interrupt lines into three banks of 32 and raises one request line towards a processor. Software works it through a 32-bit register port with a 12-bit byte address. Per bank, software can mask sources by writing the mask word directly. It can also set or clear mask bits atomically through write-one registers. A masked-pending word shows which enabled lines are currently high.

Each source carries a 6-bit priority, and a global threshold can filter out weak sources. When no interrupt is being served, the block picks the best pending source, stores its number in the active register and raises the request line. The stored number and the request stay fixed until software writes the acknowledge bit. One cycle after that write the search runs again and presents the next source.

A soft reset, started from the configuration register, puts the mask, priority and threshold state back to its power-on values within four clock cycles. A status bit shows when the soft reset has finished.

Top module: `irqc_top`

## Requirements
- R1: Offset 0x000 reads the revision constant (default 0x21) in bits [7:0], and writes to it are ignored. Any offset not listed in these requirements, and any non-word-aligned offset, reads zero, and writes to it change no state.
- R2: Bank b has a mask word at 0x084 + 0x20*b. A 1 in bit i disables source 32*b+i. Every mask bit is 1 after reset. A write to this word replaces the whole mask.
- R3: A write to 0x08C + 0x20*b sets the mask bits that are 1 in the data, and a write to 0x088 + 0x20*b clears them. Bits written as 0 keep their value. Both of these offsets read zero.
- R4: Offset 0x098 + 0x20*b reads the source lines of bank b ANDed with the inverse of that bank's mask.
- R5: The priority of source n is read and written at 0x100 + 4*n in bits [7:2], and its other bits read zero. The threshold is at 0x068 in bits [5:0]. The protection bit is at 0x04C bit 0. The idle field is at 0x050 bits [1:0]. All of these read back what was written.
- R6: A source is eligible when it is pending and either the threshold is 0 or its priority value is strictly below the threshold. The winner is the eligible source with the lowest priority value. A tie goes to the lowest source number.
- R7: When no interrupt is held and an eligible source exists, the next clock edge raises irq_o and loads the winner's number into offset 0x040 bits [6:0]. While the interrupt is held, that number and irq_o do not change, even if the sources or the configuration change.
- R8: A write to 0x048 with bit 0 set releases the held interrupt, so irq_o is low in the following cycle and the next winner is presented one cycle after that. A write to 0x048 with bit 0 clear has no effect.
- R9: At 0x010, bit 0 is a read/write autoidle flag and bit 1 is a soft-reset trigger that reads 0. Setting the trigger makes the status bit at 0x014 bit 0 read 0, and it returns to 1 within 4 cycles. The soft reset sets all mask bits to 1 and clears every priority, the threshold, the protection and idle fields and any held interrupt. Register writes made while the soft reset runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Level-sensitive interrupt lines, source n on bit n |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe for addr_i |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The embedded properties check on every cycle that the set and clear writes take effect on the addressed mask bits, and that the search result always names a pending source. They also check that a held number stays frozen until an acknowledge, that the request drops right after an acknowledge, and that the soft-reset counter falls by one each cycle while the request stays low. Only the bench's scenarios can show that the chosen source is the correct one under a given mix of priorities, ties and thresholds, and that register read-back and address decoding are right. The bench also confirms that the soft reset finishes in the stated number of cycles and leaves the full state at its power-on values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W      = 32;
  localparam int unsigned PRIO_W      = 6;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned BANK_STRIDE = 32;

  localparam logic [ADDR_W-1:0] OFF_REV    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SYSCFG = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_ACTIVE = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_PROT   = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_IDLE   = 12'h050;
  localparam logic [ADDR_W-1:0] OFF_THR    = 12'h068;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h084;
  localparam logic [ADDR_W-1:0] OFF_MCLR   = 12'h088;
  localparam logic [ADDR_W-1:0] OFF_MSET   = 12'h08C;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 12'h098;
  localparam logic [ADDR_W-1:0] OFF_PRIO   = 12'h100;

  // Threshold zero disables filtering; otherwise a strictly smaller value passes.
  function automatic logic prio_pass(input logic [PRIO_W-1:0] p,
                                     input logic [PRIO_W-1:0] thr);
    return (thr == '0) || (p < thr);
  endfunction

  // Address of a per-bank register for bank b.
  function automatic logic [ADDR_W-1:0] bank_reg(input logic [ADDR_W-1:0] off,
                                                 input int unsigned b);
    return off + ADDR_W'(BANK_STRIDE * b);
  endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_mask_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] src_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] pend_o
);
  logic [BANK_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (clear_i)   mask_q <= '1;
    else if (wr_mask_i) mask_q <= wdata_i;
    else if (wr_set_i)  mask_q <= mask_q | wdata_i;
    else if (wr_clr_i)  mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
  assign pend_o = src_i & ~mask_q;

  p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_i && !clear_i && !wr_mask_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  p_clr_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_i && !clear_i && !wr_mask_i |=> ((mask_o & $past(wdata_i)) == '0));
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (&mask_o));
endmodule

// File: rtl/irqc_sorter.sv
module irqc_sorter
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC  = 96,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          pend_i,
  input  logic [NSRC*PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]        thr_i,
  output logic                     win_valid_o,
  output logic [IDX_W-1:0]         win_idx_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best_p      = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && prio_pass(prio_i[i*PRIO_W +: PRIO_W], thr_i) &&
          (!win_valid_o || prio_i[i*PRIO_W +: PRIO_W] < best_p)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best_p      = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  p_win_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> pend_i[win_idx_o]);
  p_none_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !win_valid_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NBANK    = 3,
  parameter logic [7:0]  REV      = 8'h21,
  parameter int unsigned SRST_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic                    wr_en_i,
  output logic [31:0]             rdata_o,
  output logic                    irq_o
);
  localparam int unsigned NSRC  = NBANK * BANK_W;
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned CNT_W = $clog2(SRST_CYC + 1);

  // named internal events
  logic             busy, wr_ok, srst_start, ack_evt;
  logic             prio_hit;
  logic [IDX_W-1:0] prio_idx;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;

  logic [CNT_W-1:0]  srst_cnt_q;
  logic              autoidle_q, prot_q, held_q;
  logic [1:0]        idle_q;
  logic [PRIO_W-1:0] thr_q;
  logic [IDX_W-1:0]  active_q;
  logic [PRIO_W-1:0] prio_q [NSRC];

  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        pend_flat;
  logic [BANK_W-1:0]      mask_w [NBANK];

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return IDX_W'((a - OFF_PRIO) >> 2);
  endfunction

  assign busy       = (srst_cnt_q != '0);
  assign wr_ok      = wr_en_i && !busy;
  assign srst_start = wr_ok && (addr_i == OFF_SYSCFG) && wdata_i[1];
  assign ack_evt    = wr_ok && (addr_i == OFF_CTRL) && wdata_i[0];
  assign prio_hit   = (addr_i >= OFF_PRIO) &&
                      (addr_i < OFF_PRIO + ADDR_W'(4 * NSRC)) &&
                      (addr_i[1:0] == 2'b00);
  assign prio_idx   = slot_of(addr_i);

  // soft reset sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          srst_cnt_q <= '0;
    else if (srst_start) srst_cnt_q <= CNT_W'(SRST_CYC - 1);
    else if (busy)       srst_cnt_q <= srst_cnt_q - CNT_W'(1);
  end

  // mask banks
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqc_mask_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (srst_start),
      .wr_mask_i (wr_ok && (addr_i == bank_reg(OFF_MASK, b))),
      .wr_set_i  (wr_ok && (addr_i == bank_reg(OFF_MSET, b))),
      .wr_clr_i  (wr_ok && (addr_i == bank_reg(OFF_MCLR, b))),
      .wdata_i   (wdata_i),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .mask_o    (mask_w[b]),
      .pend_o    (pend_flat[b*BANK_W +: BANK_W])
    );
  end

  // priority table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (srst_start) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (wr_ok && prio_hit) begin
      prio_q[prio_idx] <= wdata_i[PRIO_W+1:2];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flat
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  // configuration fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= '0;
      thr_q      <= '0;
    end else if (wr_ok) begin
      if (addr_i == OFF_SYSCFG) autoidle_q <= wdata_i[0];
      if (srst_start) begin
        prot_q <= 1'b0;
        idle_q <= '0;
        thr_q  <= '0;
      end else begin
        if (addr_i == OFF_PROT) prot_q <= wdata_i[0];
        if (addr_i == OFF_IDLE) idle_q <= wdata_i[1:0];
        if (addr_i == OFF_THR)  thr_q  <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  irqc_sorter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sort (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_flat),
    .prio_i      (prio_flat),
    .thr_i       (thr_q),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  // active latch and acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      active_q <= '0;
    end else if (srst_start) begin
      held_q   <= 1'b0;
      active_q <= '0;
    end else if (!busy) begin
      if (ack_evt) begin
        held_q <= 1'b0;
      end else if (!held_q && win_valid) begin
        held_q   <= 1'b1;
        active_q <= win_idx;
      end
    end
  end

  assign irq_o = held_q;

  // register read
  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_REV)         rdata_o[7:0] = REV;
    else if (addr_i == OFF_SYSCFG) rdata_o[0]   = autoidle_q;
    else if (addr_i == OFF_STATUS) rdata_o[0]   = !busy;
    else if (addr_i == OFF_ACTIVE) rdata_o[IDX_W-1:0] = active_q;
    else if (addr_i == OFF_PROT)   rdata_o[0]   = prot_q;
    else if (addr_i == OFF_IDLE)   rdata_o[1:0] = idle_q;
    else if (addr_i == OFF_THR)    rdata_o[PRIO_W-1:0] = thr_q;
    else if (prio_hit)             rdata_o[PRIO_W+1:2] = prio_q[prio_idx];
    for (int b = 0; b < NBANK; b++) begin
      if (addr_i == bank_reg(OFF_MASK, b)) rdata_o = mask_w[b];
      if (addr_i == bank_reg(OFF_PEND, b)) rdata_o = pend_flat[b*BANK_W +: BANK_W];
    end
  end

  p_active_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !ack_evt && !srst_start |=> $stable(active_q) && irq_o);
  p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && ack_evt |=> !irq_o);
  p_reset_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_start |=> busy);
  p_reset_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((srst_cnt_q + CNT_W'(1)) == $past(srst_cnt_q)));
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_o);
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_mask [3];
  logic [5:0]  m_prio [96];
  logic [5:0]  m_thr;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .wdata_i(wdata), .wr_en_i(wr_en), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [11:0] mreg(input int base, input int b);
    return 12'(base + 32 * b);
  endfunction

  // reference winner: scan priority levels from best, first eligible source wins
  function automatic logic [7:0] ref_win(input logic [95:0] s);
    for (int lvl = 0; lvl < 64; lvl++) begin
      if (m_thr != 0 && lvl >= m_thr) return 8'h00;
      for (int n = 0; n < 96; n++)
        if (s[n] && !m_mask[n/32][n%32] && m_prio[n] == 6'(lvl))
          return {1'b1, 7'(n)};
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 3; b++) m_mask[b] = '1;
    for (int n = 0; n < 96; n++) m_prio[n] = '0;
    m_thr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  w;
    int n;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(12'h000, v); chk("R1 revision", v, 32'h21);
    rd(12'h014, v); chk("R9 status after reset", v, 32'h1);
    for (int b = 0; b < 3; b++) begin
      rd(mreg('h84, b), v); chk("R2 mask reset", v, 32'hFFFF_FFFF);
    end
    chk("R7 irq after reset", {31'b0, irq}, 32'h0);
    src = '1; #1;
    rd(12'h098, v); chk("R4 pending while masked", v, 32'h0);
    src = '0;

    // mask set/clear/direct write
    wr(mreg('h88, 1), 32'h0000_00F0);
    rd(mreg('h84, 1), v); chk("R3 mask clear", v, 32'hFFFF_FF0F);
    wr(mreg('h8C, 1), 32'h0000_0030);
    rd(mreg('h84, 1), v); chk("R3 mask set", v, 32'hFFFF_FF3F);
    rd(mreg('h88, 1), v); chk("R3 clear reads zero", v, 32'h0);
    wr(mreg('h84, 2), 32'h1234_5678);
    rd(mreg('h84, 2), v); chk("R2 direct mask write", v, 32'h1234_5678);
    wr(mreg('h84, 2), 32'hFFFF_FFFF);

    // pending and tie-break: bank 1 bits 6,7 unmasked, both priority 0
    @(negedge clk); src = '0; src[38] = 1'b1; src[39] = 1'b1; src[40] = 1'b1;
    #1; rd(mreg('h98, 1), v); chk("R4 pending bank1", v, 32'h0000_00C0);
    @(negedge clk);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    rd(12'h040, v); chk("R6 tie to lowest source", v, 32'd38);

    // frozen while held
    @(negedge clk); src[38] = 1'b0;
    @(negedge clk);
    rd(12'h040, v); chk("R7 active frozen", v, 32'd38);
    wr(12'h048, 32'h0);
    chk("R8 zero write no ack", {31'b0, irq}, 32'h1);
    wr(12'h048, 32'h1);
    chk("R8 irq low after ack", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 next presented", {31'b0, irq}, 32'h1);
    rd(12'h040, v); chk("R8 next source", v, 32'd39);

    // priority and threshold
    src = '0;
    wr(12'h048, 32'h1);
    wr(12'h100 + 12'd4 * 12'd39, 32'hFF);
    rd(12'h100 + 12'd4 * 12'd39, v); chk("R5 priority field", v, 32'hFC);
    wr(12'h100 + 12'd4 * 12'd39, 32'd3 << 2);
    wr(12'h100 + 12'd4 * 12'd38, 32'd10 << 2);
    wr(12'h068, 32'd3);
    rd(12'h068, v); chk("R5 threshold", v, 32'd3);
    @(negedge clk); src[38] = 1'b1; src[39] = 1'b1;
    wr(mreg('h88, 1), 32'h0000_0040);
    @(negedge clk);
    chk("R6 threshold blocks", {31'b0, irq}, 32'h0);
    wr(12'h068, 32'd4);
    @(negedge clk);
    chk("R6 threshold passes", {31'b0, irq}, 32'h1);
    rd(12'h040, v); chk("R6 best priority wins", v, 32'd39);

    // unimplemented offsets and plain fields
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h044, v); chk("R1 unimplemented reads zero", v, 32'h0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R1 revision write ignored", v, 32'h21);
    rd(12'h280, v); chk("R1 past priority table", v, 32'h0);
    rd(12'h101, v); chk("R1 misaligned", v, 32'h0);
    rd(12'h040, v); chk("R1 stray writes left active", v, 32'd39);
    wr(12'h04C, 32'hFFFF_FFFF);
    rd(12'h04C, v); chk("R5 protection", v, 32'h1);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, v); chk("R5 idle field", v, 32'h3);
    wr(12'h010, 32'h1);
    rd(12'h010, v); chk("R9 autoidle", v, 32'h1);

    // soft reset with an interrupt held
    wr(12'h010, 32'h2);
    rd(12'h014, v); chk("R9 status low during reset", v, 32'h0);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);
    n = 0;
    while (v[0] == 1'b0 && n < 8) begin
      @(negedge clk); n++;
      rd(12'h014, v);
    end
    chk("R9 reset within 4 cycles", {31'b0, (n >= 1 && n <= 3)}, 32'h1);
    model_reset();
    rd(mreg('h84, 1), v); chk("R9 masks restored", v, 32'hFFFF_FFFF);
    rd(12'h100 + 12'd4 * 12'd39, v); chk("R9 priority cleared", v, 32'h0);
    rd(12'h068, v); chk("R9 threshold cleared", v, 32'h0);
    rd(12'h04C, v); chk("R9 protection cleared", v, 32'h0);
    rd(12'h010, v); chk("R9 trigger reads zero", v, 32'h0);
    chk("R9 irq stays low", {31'b0, irq}, 32'h0);

    // constrained random rounds against the reference model
    for (int it = 0; it < 40; it++) begin
      logic [31:0] r;
      int bk;
      @(negedge clk); src = '0;
      wr(12'h048, 32'h1);
      for (int b = 0; b < 3; b++) begin
        r = $urandom;
        wr(mreg('h88, b), r); m_mask[b] = m_mask[b] & ~r;
        r = $urandom & $urandom;
        wr(mreg('h8C, b), r); m_mask[b] = m_mask[b] | r;
      end
      for (int k = 0; k < 6; k++) begin
        int s;
        logic [5:0] p;
        s = int'($urandom % 96);
        p = 6'($urandom % 64);
        wr(12'(256 + 4 * s), {24'b0, p, 2'b00});
        m_prio[s] = p;
      end
      m_thr = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom % 64);
      wr(12'h068, {26'b0, m_thr});
      @(negedge clk);
      src = {$urandom, $urandom, $urandom};
      @(negedge clk);
      w = ref_win(src);
      chk("R6 random irq", {31'b0, irq}, {31'b0, w[7]});
      if (w[7]) begin
        rd(12'h040, v); chk("R6 random winner", v, {25'b0, w[6:0]});
      end
      bk = int'($urandom % 3);
      rd(mreg('h98, bk), v);
      chk("R4 random pending", v, src[bk*32 +: 32] & ~m_mask[bk]);
    end

    summary();
  end
endmodule